// File: doc/BRIEF.md
# Byte-Wide Programming Operation Register

This block is the device side of a 27-bit data register used for in-system programming of a small byte-addressed flash array. It sits behind a JTAG TAP that is not part of this block. The TAP controller supplies the capture, shift and update strobes, a level that is high while the TAP rests in Run-Test/Idle, and a 3-bit operation mode decoded from the instruction register. The host loads a frame that holds a two-bit control code, a data byte and an address. The control code 0b10 arms an operation. The operation then runs while the TAP stays in Run-Test/Idle. Its result is returned in the low two bits of the frame captured on the next shift.

Program and erase take a fixed number of idle clocks and are counted inside the block. A read takes a single idle clock. Leaving Run-Test/Idle early, or capturing the register before the operation ends, aborts the operation and returns a code that depends on the operation. Because every result is captured at the start of the next shift, the host can shift in the next trigger frame while the previous result is shifted out.

Top module: `isp_oper_reg`

## Requirements
- R1: The frame is shifted least-significant bit first, with tdo carrying bit 0 and tdi entering at the top bit. Bits [1:0] hold the control code, bits [9:2] the data byte and bits [26:10] the address. In the two autoincrement modes only the low 10 bits (control and data) form the register. Mode codes: 1 program, 2 program-autoincrement, 3 read, 4 read-autoincrement, 5 erase area, 6 erase all. Mode 0 ignores updates.
- R2: An update with control 0b10 arms the selected operation, and the operation starts on the first clock spent in Run-Test/Idle. An update with any other control code starts nothing, and the next capture reports 0b11.
- R3: A program stays busy for PROG_CYCLES idle clocks after it starts. It then writes the byte and reports 0b11, with the programmed byte in the data field.
- R4: A program that would turn any 0 bit into 1, or that targets an address at or above DEPTH, leaves the array unchanged and reports 0b01.
- R5: A program that is aborted reports 0b01 and leaves the array unchanged. An abort is a drop of the idle level before completion, or a capture while the program is armed or busy.
- R6: A read completes on its first idle clock and reports 0b11, with the stored byte and the address in their fields. An address at or above DEPTH reports 0b10 with data 0x00.
- R7: Erase-area sets to 0xFF every byte of the AREA_BYTES-sized area that holds the frame address. Erase-all sets every byte to 0xFF. Both take ERASE_CYCLES idle clocks and report 0b11.
- R8: An aborted erase reports 0b00 and leaves the array unchanged.
- R9: Write protection is active after reset. An erase started while protected changes nothing and reports 0b10. A trigger frame with address 0x1AA55 in either erase mode clears protection, starts no operation and reports 0b11.
- R10: In the autoincrement modes, a trigger frame first advances the held address by one, wrapping from DEPTH-1 to 0, and then runs the operation at the new address.
- R11: Reset gives status 0b11, data 0x00, address 0, every array byte 0xFF, and protection active.
- R12: The frame captured at the start of a shift carries the result of the most recent operation, so trigger frames can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| isp_mode | input | 3 | Operation mode from the instruction decode |
| dr_capture | input | 1 | TAP in Capture-DR |
| dr_shift | input | 1 | TAP in Shift-DR |
| dr_update | input | 1 | TAP in Update-DR |
| tap_idle | input | 1 | TAP in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the register) |

## Verification
The assertions check the following on every cycle:
- an erase never reaches the array while protection is set;
- a program never raises a bit;
- the operation counter stays within its limit;
- a read leaves the armed state after one idle clock;
- leaving idle during a busy operation always ends in an abort code;
- autoincrement keeps the address in range;
- an autoincrement shift never disturbs the address bits.

Only the bench scenarios can show the rest. These cover:
- the actual status codes and data seen on tdo after each operation;
- the back-to-back overlap of results with new triggers;
- that aborted and failed operations really leave the array contents intact;
- the unlock key;
- that reset restores both the array and protection.

// File: rtl/isp_pkg.sv
// Shared constants and types for the programming operation register.
// Assumes a 27-bit full frame and a 10-bit short frame for autoincrement modes.
package isp_pkg;
    localparam int FRAME_W = 27;
    localparam int SHORT_W = 10;
    localparam int ADDR_FW = 17;
    localparam int DATA_W  = 8;

    localparam logic [1:0] CTL_TRIGGER     = 2'b10;
    localparam logic [1:0] ST_OK           = 2'b11;
    localparam logic [1:0] ST_PROG_FAIL    = 2'b01;
    localparam logic [1:0] ST_ERASE_ABORT  = 2'b00;
    localparam logic [1:0] ST_ERROR        = 2'b10;
    localparam logic [ADDR_FW-1:0] UNLOCK_KEY = 17'h1aa55;

    typedef enum logic [2:0] {
        M_NONE     = 3'd0,
        M_PROG     = 3'd1,
        M_PROG_INC = 3'd2,
        M_VFY      = 3'd3,
        M_VFY_INC  = 3'd4,
        M_ERASE    = 3'd5,
        M_BULK     = 3'd6
    } isp_mode_e;

    typedef enum logic [1:0] {K_NONE, K_PROG, K_VFY, K_ERASE} op_e;

    typedef enum logic [1:0] {S_IDLE, S_ARMED, S_BUSY} op_state_e;
endpackage

// File: rtl/isp_dr_shifter.sv
// Capture/shift register for the frame.
// Assumes capture and shift are never high in the same cycle.
// In short form only the low SHORT_W bits shift; the upper bits hold.
module isp_dr_shifter
    import isp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               shift,
    input  logic               short_form,
    input  logic               tdi,
    input  logic [FRAME_W-1:0] cap_frame,
    output logic [FRAME_W-1:0] frame_q,
    output logic               tdo
);
    // Load the status frame on capture, otherwise move one bit toward tdo per shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (capture) begin
            frame_q <= cap_frame;
        end else if (shift) begin
            if (short_form)
                frame_q <= {frame_q[FRAME_W-1:SHORT_W], tdi, frame_q[SHORT_W-1:1]};
            else
                frame_q <= {tdi, frame_q[FRAME_W-1:1]};
        end
    end

    assign tdo = frame_q[0];

    AST_SHORT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && short_form && !capture) |=> frame_q[FRAME_W-1:SHORT_W] == $past(frame_q[FRAME_W-1:SHORT_W])); // R1
endmodule

// File: rtl/isp_byte_array.sv
// Small byte-wide flash model.
// Program writes one byte. Erase fills an area, or every byte, with 0xFF.
// Assumes DEPTH and AREA_BYTES are powers of two and the controller never raises a bit.
module isp_byte_array
    import isp_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int AREA_BYTES = 8,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int AREA_SH   = $clog2(AREA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic              erase_all,
    input  logic [IDX_W-1:0]  erase_idx
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        localparam logic [IDX_W-1:0] MY_AREA = IDX_W'(i / AREA_BYTES);
        logic hit_area;
        assign hit_area = erase_all || ((erase_idx >> AREA_SH) == MY_AREA);
        // One byte cell: reset and erase to all ones, program to the supplied byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (erase_en && hit_area)
                mem[i] <= '1;
            else if (prog_en && prog_idx == IDX_W'(i))
                mem[i] <= prog_data;
        end
    end

    assign rd_data = mem[rd_idx];

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> ((prog_data & ~mem[prog_idx]) == '0)); // R4
    AST_BULK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && erase_all) |=> (mem[0] == '1 && mem[DEPTH-1] == '1)); // R7
endmodule

// File: rtl/isp_op_ctrl.sv
// Operation sequencer.
// Decodes updated frames, arms operations, counts idle clocks, applies write
// protection, and builds the frame captured next.
// Assumes update and capture never coincide, and that the mode is stable around an update.
module isp_op_ctrl
    import isp_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32,
    parameter bit WP_AT_RESET  = 1'b1,
    localparam int IDX_W       = $clog2(DEPTH),
    localparam int MAXC        = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W       = $clog2(MAXC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         isp_mode,
    input  logic               dr_capture,
    input  logic               dr_update,
    input  logic               tap_idle,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               short_form,
    output logic [FRAME_W-1:0] cap_frame,
    output logic [IDX_W-1:0]   mem_idx,
    output logic               prog_en,
    output logic [DATA_W-1:0]  prog_data,
    output logic               erase_en,
    output logic               erase_all
);
    isp_mode_e         mode;
    op_state_e         state_q;
    op_e               op_q;
    logic              all_q;
    logic              wp_q;
    logic [ADDR_FW-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        status_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [1:0]         fr_ctl;
    logic [DATA_W-1:0]  fr_data;
    logic [ADDR_FW-1:0] fr_addr;
    logic               in_range;
    logic [ADDR_FW-1:0] next_addr;
    logic [CNT_W-1:0]   limit;
    logic [1:0]         abort_code;
    logic               is_erase_mode;
    logic               finishing;

    assign mode          = isp_mode_e'(isp_mode);
    assign short_form    = (mode == M_PROG_INC) || (mode == M_VFY_INC);
    assign is_erase_mode = (mode == M_ERASE) || (mode == M_BULK);
    assign fr_ctl        = frame[1:0];
    assign fr_data       = frame[9:2];
    assign fr_addr       = frame[FRAME_W-1:SHORT_W];
    assign in_range      = addr_q < ADDR_FW'(DEPTH);
    assign next_addr     = (addr_q >= ADDR_FW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
    assign limit         = (op_q == K_ERASE) ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
    assign mem_idx       = addr_q[IDX_W-1:0];
    assign prog_data     = data_q;
    assign erase_all     = all_q;

    // Abort result depends on the operation that was cut short.
    always_comb begin
        case (op_q)
            K_PROG:  abort_code = ST_PROG_FAIL;
            K_ERASE: abort_code = ST_ERASE_ABORT;
            default: abort_code = ST_ERROR;
        endcase
    end

    // Capture sees the abort code at once when it interrupts an operation.
    assign cap_frame = {addr_q, data_q,
                        (dr_capture && state_q != S_IDLE) ? abort_code : status_q};

    // Last counted idle clock of a busy operation writes the array.
    assign finishing = (state_q == S_BUSY) && tap_idle && !dr_capture && !dr_update
                       && (cnt_q == limit);
    assign prog_en   = finishing && (op_q == K_PROG);
    assign erase_en  = finishing && (op_q == K_ERASE);

    // Frame decode, operation sequencing and result recording.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= K_NONE;
            all_q    <= 1'b0;
            wp_q     <= WP_AT_RESET;
            addr_q   <= '0;
            data_q   <= '0;
            status_q <= ST_OK;
            cnt_q    <= '0;
        end else if (dr_update && mode != M_NONE) begin
            data_q <= fr_data;
            if (!short_form)
                addr_q <= fr_addr;
            state_q  <= S_IDLE;
            status_q <= ST_OK;
            if (fr_ctl == CTL_TRIGGER) begin
                if (is_erase_mode && fr_addr == UNLOCK_KEY) begin
                    wp_q <= 1'b0;
                end else begin
                    state_q <= S_ARMED;
                    all_q   <= (mode == M_BULK);
                    if (short_form)
                        addr_q <= next_addr;
                    case (mode)
                        M_PROG, M_PROG_INC: op_q <= K_PROG;
                        M_VFY, M_VFY_INC:   op_q <= K_VFY;
                        default:            op_q <= K_ERASE;
                    endcase
                end
            end
        end else if (dr_capture && state_q != S_IDLE) begin
            state_q  <= S_IDLE;
            status_q <= abort_code;
        end else begin
            case (state_q)
                S_ARMED: begin
                    if (tap_idle) begin
                        case (op_q)
                            K_VFY: begin
                                data_q   <= in_range ? rd_data : '0;
                                status_q <= in_range ? ST_OK : ST_ERROR;
                                state_q  <= S_IDLE;
                            end
                            K_PROG: begin
                                if (!in_range || (data_q & ~rd_data) != '0) begin
                                    status_q <= ST_PROG_FAIL;
                                    state_q  <= S_IDLE;
                                end else begin
                                    state_q <= S_BUSY;
                                    cnt_q   <= CNT_W'(1);
                                end
                            end
                            default: begin
                                if (wp_q) begin
                                    status_q <= ST_ERROR;
                                    state_q  <= S_IDLE;
                                end else begin
                                    state_q <= S_BUSY;
                                    cnt_q   <= CNT_W'(1);
                                end
                            end
                        endcase
                    end
                end
                S_BUSY: begin
                    if (!tap_idle) begin
                        state_q  <= S_IDLE;
                        status_q <= abort_code;
                    end else if (cnt_q == limit) begin
                        state_q  <= S_IDLE;
                        status_q <= ST_OK;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_ERASE_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> !wp_q); // R9
    AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY) |-> (cnt_q != '0 && cnt_q <= limit)); // R3
    AST_READ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && op_q == K_VFY && tap_idle && !dr_update && !dr_capture)
        |=> (state_q == S_IDLE && status_q != ST_PROG_FAIL)); // R6
    AST_EXIT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && !tap_idle && !dr_update)
        |=> (state_q == S_IDLE && (status_q == ST_PROG_FAIL || status_q == ST_ERASE_ABORT))); // R5
    AST_INC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_update && short_form && fr_ctl == CTL_TRIGGER) |=> (addr_q < ADDR_FW'(DEPTH))); // R10
endmodule

// File: rtl/isp_oper_reg.sv
// Top of the programming operation register: shifter, sequencer and byte array.
// Assumes TAP state strobes are one-hot and synchronous to tck.
module isp_oper_reg
    import isp_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int AREA_BYTES   = 8,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 32,
    parameter bit WP_AT_RESET  = 1'b1,
    localparam int IDX_W       = $clog2(DEPTH)
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic [2:0] isp_mode,
    input  logic       dr_capture,
    input  logic       dr_shift,
    input  logic       dr_update,
    input  logic       tap_idle,
    input  logic       tdi,
    output logic       tdo
);
    logic               short_form;
    logic [FRAME_W-1:0] cap_frame;
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   mem_idx;
    logic [DATA_W-1:0]  rd_data;
    logic               prog_en;
    logic [DATA_W-1:0]  prog_data;
    logic               erase_en;
    logic               erase_all;

    isp_dr_shifter u_shift (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture    (dr_capture),
        .shift      (dr_shift),
        .short_form (short_form),
        .tdi        (tdi),
        .cap_frame  (cap_frame),
        .frame_q    (frame_q),
        .tdo        (tdo)
    );

    isp_op_ctrl #(
        .DEPTH        (DEPTH),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .WP_AT_RESET  (WP_AT_RESET)
    ) u_ctrl (
        .clk        (tck),
        .rst_n      (rst_n),
        .isp_mode   (isp_mode),
        .dr_capture (dr_capture),
        .dr_update  (dr_update),
        .tap_idle   (tap_idle),
        .frame      (frame_q),
        .rd_data    (rd_data),
        .short_form (short_form),
        .cap_frame  (cap_frame),
        .mem_idx    (mem_idx),
        .prog_en    (prog_en),
        .prog_data  (prog_data),
        .erase_en   (erase_en),
        .erase_all  (erase_all)
    );

    isp_byte_array #(
        .DEPTH      (DEPTH),
        .AREA_BYTES (AREA_BYTES)
    ) u_array (
        .clk       (tck),
        .rst_n     (rst_n),
        .rd_idx    (mem_idx),
        .rd_data   (rd_data),
        .prog_en   (prog_en),
        .prog_idx  (mem_idx),
        .prog_data (prog_data),
        .erase_en  (erase_en),
        .erase_all (erase_all),
        .erase_idx (mem_idx)
    );
endmodule

// File: tb/isp_oper_reg_test.sv
// Bench: a vector table of frames walked in order.
// Each row shifts its frame, checks the result of the previous row on tdo,
// then idles. Directed reset checks follow.
module isp_oper_reg_test;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] isp_mode = 3'd0;
    logic       dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tap_idle = 1'b0, tdi = 1'b0;
    logic       tdo;
    int checks = 0;
    int errors = 0;

    always #2.5 tck = ~tck;

    isp_oper_reg uut (
        .tck(tck), .rst_n(rst_n), .isp_mode(isp_mode), .dr_capture(dr_capture),
        .dr_shift(dr_shift), .dr_update(dr_update), .tap_idle(tap_idle), .tdi(tdi), .tdo(tdo)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  ctl;
        logic [16:0] addr;
        logic [7:0]  data;
        logic [7:0]  idle;
        logic [1:0]  ex_st;
        logic [7:0]  ex_dat;
        logic        chk_a;
        logic [16:0] ex_addr;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VT [NV] = '{
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'h00, 1'b1, 17'd0},  // R11 reset state
        '{3'd1, 2'b10, 17'd3,  8'hA5, 8'd20, 2'b11, 8'hFF, 1'b1, 17'd3},  // R6 read erased byte
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'hA5, 1'b0, 17'd0},  // R3 program ok
        '{3'd1, 2'b10, 17'd3,  8'hFF, 8'd20, 2'b11, 8'hA5, 1'b0, 17'd0},  // R3 read back
        '{3'd1, 2'b10, 17'd3,  8'h21, 8'd20, 2'b01, 8'hFF, 1'b0, 17'd0},  // R4 raise bit fails
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'h21, 1'b0, 17'd0},  // R3 clear-only ok
        '{3'd3, 2'b10, 17'd20, 8'h00, 8'd2,  2'b11, 8'h21, 1'b0, 17'd0},  // R12 overlap
        '{3'd1, 2'b10, 17'd4,  8'h00, 8'd5,  2'b10, 8'h00, 1'b1, 17'd20}, // R6 out of range
        '{3'd3, 2'b10, 17'd4,  8'h00, 8'd2,  2'b01, 8'h00, 1'b0, 17'd0},  // R5 early exit
        '{3'd5, 2'b10, 17'd0,  8'h00, 8'd40, 2'b11, 8'hFF, 1'b0, 17'd0},  // R5 array kept
        '{3'd5, 2'b10, 17'h1aa55, 8'h00, 8'd2, 2'b10, 8'h00, 1'b0, 17'd0}, // R9 protected
        '{3'd5, 2'b10, 17'd0,  8'h00, 8'd40, 2'b11, 8'h00, 1'b0, 17'd0},  // R9 unlock no-op
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'h00, 1'b0, 17'd0},  // R7 erase ok
        '{3'd1, 2'b10, 17'd10, 8'h0F, 8'd20, 2'b11, 8'hFF, 1'b0, 17'd0},  // R7 area 0 erased
        '{3'd5, 2'b10, 17'd12, 8'h00, 8'd10, 2'b11, 8'h0F, 1'b0, 17'd0},  // R3
        '{3'd3, 2'b10, 17'd10, 8'h00, 8'd2,  2'b00, 8'h00, 1'b0, 17'd0},  // R8 erase abort
        '{3'd1, 2'b10, 17'd5,  8'h11, 8'd20, 2'b11, 8'h0F, 1'b0, 17'd0},  // R8 array kept
        '{3'd2, 2'b10, 17'd0,  8'h22, 8'd20, 2'b11, 8'h11, 1'b0, 17'd0},  // R1 short frame
        '{3'd3, 2'b10, 17'd5,  8'h00, 8'd2,  2'b11, 8'h22, 1'b1, 17'd6},  // R10 inc program
        '{3'd4, 2'b10, 17'd0,  8'h00, 8'd2,  2'b11, 8'h11, 1'b0, 17'd0},  // R10 prior byte
        '{3'd6, 2'b10, 17'd0,  8'h00, 8'd40, 2'b11, 8'h22, 1'b1, 17'd6},  // R10 inc read
        '{3'd3, 2'b10, 17'd10, 8'h00, 8'd2,  2'b11, 8'h00, 1'b0, 17'd0},  // R7 bulk ok
        '{3'd3, 2'b11, 17'd0,  8'h00, 8'd2,  2'b11, 8'hFF, 1'b0, 17'd0},  // R7 bulk erased
        '{3'd1, 2'b01, 17'd3,  8'h00, 8'd20, 2'b11, 8'h00, 1'b0, 17'd0},  // R2 neutral
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'h00, 1'b0, 17'd0},  // R2 no trigger
        '{3'd3, 2'b11, 17'd0,  8'h00, 8'd2,  2'b11, 8'hFF, 1'b0, 17'd0},  // R2 byte untouched
        '{3'd1, 2'b10, 17'd3,  8'h00, 8'd0,  2'b11, 8'h00, 1'b0, 17'd0},  // R2
        '{3'd3, 2'b11, 17'd0,  8'h00, 8'd2,  2'b01, 8'h00, 1'b0, 17'd0},  // R5 capture abort
        '{3'd3, 2'b10, 17'd3,  8'h00, 8'd2,  2'b11, 8'h00, 1'b0, 17'd0},  // R2
        '{3'd1, 2'b10, 17'd3,  8'h55, 8'd20, 2'b11, 8'hFF, 1'b0, 17'd0},  // R5 still erased
        '{3'd3, 2'b11, 17'd0,  8'h00, 8'd2,  2'b11, 8'h55, 1'b1, 17'd3}   // R3 with address
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame: capture, shift in while collecting the old frame, update, idle.
    task automatic run_frame(input vec_t v, input string tag);
        logic [26:0] fin;
        logic [26:0] fout;
        int len;
        fin  = {v.addr, v.data, v.ctl};
        fout = '0;
        len  = (v.mode == 3'd2 || v.mode == 3'd4) ? 10 : 27;
        @(negedge tck);
        isp_mode   = v.mode;
        dr_capture = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge tck);
            dr_capture = 1'b0;
            dr_shift   = 1'b1;
            tdi        = fin[i];
            fout[i]    = tdo;
        end
        @(negedge tck);
        dr_shift  = 1'b0;
        dr_update = 1'b1;
        @(negedge tck);
        dr_update = 1'b0;
        check({tag, " status"}, 32'(fout[1:0]), 32'(v.ex_st));
        check({tag, " data"}, 32'(fout[9:2]), 32'(v.ex_dat));
        if (v.chk_a && len == 27)
            check({tag, " addr"}, 32'(fout[26:10]), 32'(v.ex_addr));
        tap_idle = (v.idle != 0);
        repeat (int'(v.idle)) @(negedge tck);
        tap_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        errors++;
        $display("FAIL watchdog R12 actual=hang expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        check("R11 tdo after reset", 32'(tdo), 32'(0));
        for (int n = 0; n < NV; n++)
            run_frame(VT[n], $sformatf("row%0d", n));
        // Directed: reset restores array contents and protection (R11, R9).
        @(negedge tck);
        rst_n = 1'b0;
        repeat (2) @(negedge tck);
        rst_n = 1'b1;
        run_frame('{3'd3, 2'b10, 17'd3, 8'h00, 8'd2, 2'b11, 8'h00, 1'b1, 17'd0}, "R11 regs after reset");
        run_frame('{3'd5, 2'b10, 17'd0, 8'h00, 8'd40, 2'b11, 8'hFF, 1'b1, 17'd3}, "R11 array after reset");
        run_frame('{3'd3, 2'b11, 17'd0, 8'h00, 8'd2, 2'b10, 8'h00, 1'b0, 17'd0}, "R9 protection reloaded");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule